// File: doc/BRIEF.md
# Two-Way Translation Buffer with Trap-on-Miss Refill

This block translates 40-bit virtual addresses into 36-bit physical addresses for a core that uses 16 KB pages. It caches 512 page mappings as 256 sets of two ways. The set is picked by eight bits of the virtual page number, and the remaining eighteen bits are compared as a tag. Each cached mapping carries a two-bit permission code, a dirty flag for write-back tracking and a referenced flag for the operating system's replacement bookkeeping.

The block has no page-table walker. When no mapping matches, the response is flagged as a miss, which the core turns into a trap. The handler then installs a mapping through the fill port. The fill port either names a way or lets the block choose the least-recently-used way of the set. The handler can read any stored mapping, and the victim choice for any set, through a combinational inspect port. A single command clears every referenced flag at once. A lookup result is registered and appears one cycle after the request.

Top module: `vxlat_tlb`

## Requirements
- R1: A lookup that hits returns, one cycle after the request, a physical address made of the stored 22-bit page number above the unchanged low 14 bits of the virtual address. The set is virtual address bits 21..14 and the tag is bits 39..22.
- R2: A lookup where neither way of the set holds a valid matching tag reports a miss, with hit and fault low and a zero physical address.
- R3: Permission codes are 00 none, 01 read-only, 10 read/write and 11 read/write in kernel mode only. A matching lookup that breaks its code reports a fault with a zero address, and it leaves the dirty, referenced and LRU state unchanged.
- R4: A successful hit sets the entry's referenced flag. The clear command zeroes every referenced flag and wins over a hit in the same cycle.
- R5: A successful write hit sets the entry's dirty flag.
- R6: Each set keeps a victim way, which the inspect port reports. A successful hit makes the other way the victim, and so does a fill.
- R7: A fill marks the entry valid, stores the given permission, tag, page number and dirty value, and clears its referenced flag. It writes the way named on the fill port, or the current victim when LRU selection is requested.
- R8: When a fill and a lookup address the same set in the same cycle, the fill wins. The lookup reports a miss and changes no state, and the new entry is visible to the next lookup.
- R9: Reset clears every valid, dirty, referenced and victim bit.
- R10: With no request in the previous cycle, the response outputs are all zero. With a request, exactly one of hit, miss or fault is high.
- R11: The two ways of a set hold independent mappings, and both can hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 40 | Virtual address to translate |
| lk_write | input | 1 | Lookup is a store |
| lk_kernel | input | 1 | Lookup is made in kernel mode |
| rsp_valid | output | 1 | A response is present |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No mapping; trap to refill handler |
| rsp_fault | output | 1 | Mapping found but permission broken |
| rsp_paddr | output | 36 | Translated physical address |
| fill_en | input | 1 | Install a mapping |
| fill_set | input | 8 | Set to install into |
| fill_pick_lru | input | 1 | 1: write the victim way, 0: write fill_way |
| fill_way | input | 1 | Way to write when not using the victim |
| fill_rights | input | 2 | Permission code |
| fill_tag | input | 18 | Virtual tag |
| fill_ppn | input | 22 | Physical page number |
| fill_dirty | input | 1 | Initial dirty flag |
| ref_clear | input | 1 | Clear all referenced flags |
| pr_set | input | 8 | Inspect set |
| pr_way | input | 1 | Inspect way |
| pr_valid | output | 1 | Inspected entry valid flag |
| pr_dirty | output | 1 | Inspected entry dirty flag |
| pr_ref | output | 1 | Inspected entry referenced flag |
| pr_rights | output | 2 | Inspected entry permission code |
| pr_tag | output | 18 | Inspected entry tag |
| pr_ppn | output | 22 | Inspected entry page number |
| pr_victim | output | 1 | Victim way of the inspected set |

## Verification
The assertions assume that no lookup is issued until the internal reset has been released, which happens two clocks after rst_n rises. The bench waits several idle cycles after reset before it drives anything. Both the checks and the translation assume that software never installs the same tag in both ways of one set. When a random fill would create such a duplicate, the bench drops that fill. The random addresses and tags are drawn from small pools of sets and tags, so that hits, faults, same-set collisions and evictions all occur often.

// File: rtl/vxlat_pkg.sv
package vxlat_pkg;
  localparam int VA_W   = 40;
  localparam int PA_W   = 36;
  localparam int OFF_W  = 14;
  localparam int SET_W  = 8;
  localparam int SETS   = 1 << SET_W;
  localparam int WAYS   = 2;
  localparam int WAY_W  = $clog2(WAYS);
  localparam int VPN_W  = VA_W - OFF_W;
  localparam int TAG_W  = VPN_W - SET_W;
  localparam int PPN_W  = PA_W - OFF_W;

  typedef enum logic [1:0] {
    RGT_NONE = 2'b00,
    RGT_RO   = 2'b01,
    RGT_RW   = 2'b10,
    RGT_KRW  = 2'b11
  } rights_e;

  typedef struct packed {
    logic             valid;
    logic             dirty;
    logic             refd;
    rights_e          rights;
    logic [TAG_W-1:0] tag;
    logic [PPN_W-1:0] ppn;
  } entry_t;

  function automatic logic rights_ok(input rights_e r, input logic wr, input logic kern);
    case (r)
      RGT_NONE: return 1'b0;
      RGT_RO:   return !wr;
      RGT_RW:   return 1'b1;
      default:  return kern;
    endcase
  endfunction
endpackage

// File: rtl/vxlat_way_store.sv
module vxlat_way_store
  import vxlat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SET_W-1:0] wr_set,
  input  rights_e          wr_rights,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic             wr_dirty,
  input  logic             touch_en,
  input  logic [SET_W-1:0] touch_set,
  input  logic             touch_wr,
  input  logic             ref_clr,
  input  logic [SET_W-1:0] lk_set,
  output entry_t           lk_entry,
  input  logic [SET_W-1:0] pr_set,
  output entry_t           pr_entry
);
  logic [SETS-1:0]  valid_q, valid_d;
  logic [SETS-1:0]  dirty_q, dirty_d;
  logic [SETS-1:0]  ref_q,   ref_d;
  rights_e          rights_q [SETS];
  logic [TAG_W-1:0] tag_q    [SETS];
  logic [PPN_W-1:0] ppn_q    [SETS];

  // flag next state: hit update, then global clear, then fill
  always_comb begin
    valid_d = valid_q;
    dirty_d = dirty_q;
    ref_d   = ref_q;
    if (touch_en) begin
      ref_d[touch_set] = 1'b1;
      if (touch_wr) dirty_d[touch_set] = 1'b1;
    end
    if (ref_clr) ref_d = '0;
    if (wr_en) begin
      valid_d[wr_set] = 1'b1;
      dirty_d[wr_set] = wr_dirty;
      ref_d[wr_set]   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
      ref_q   <= '0;
    end else begin
      valid_q <= valid_d;
      dirty_q <= dirty_d;
      ref_q   <= ref_d;
    end
  end

  // payload fields carry no reset; valid gates their use
  always_ff @(posedge clk) begin
    if (wr_en) begin
      rights_q[wr_set] <= wr_rights;
      tag_q[wr_set]    <= wr_tag;
      ppn_q[wr_set]    <= wr_ppn;
    end
  end

  always_comb begin
    lk_entry.valid  = valid_q[lk_set];
    lk_entry.dirty  = dirty_q[lk_set];
    lk_entry.refd   = ref_q[lk_set];
    lk_entry.rights = rights_q[lk_set];
    lk_entry.tag    = tag_q[lk_set];
    lk_entry.ppn    = ppn_q[lk_set];
    pr_entry.valid  = valid_q[pr_set];
    pr_entry.dirty  = dirty_q[pr_set];
    pr_entry.refd   = ref_q[pr_set];
    pr_entry.rights = rights_q[pr_set];
    pr_entry.tag    = tag_q[pr_set];
    pr_entry.ppn    = ppn_q[pr_set];
  end
endmodule

// File: rtl/vxlat_match.sv
module vxlat_match
  import vxlat_pkg::*;
(
  input  entry_t           ents [WAYS],
  input  logic [TAG_W-1:0] tag,
  input  logic             wr,
  input  logic             kern,
  output logic             hit_any,
  output logic [WAY_W-1:0] hit_way,
  output entry_t           hit_ent,
  output logic             allowed
);
  logic [WAYS-1:0] hv;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hv[w] = ents[w].valid && (ents[w].tag == tag);
  end

  // lowest way wins should software ever leave a duplicate
  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hv[w]) hit_way = WAY_W'(w);
    end
    hit_any = |hv;
    hit_ent = ents[hit_way];
    allowed = rights_ok(hit_ent.rights, wr, kern);
  end
endmodule

// File: rtl/vxlat_lru.sv
module vxlat_lru
  import vxlat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_en,
  input  logic [SET_W-1:0] hit_set,
  input  logic [WAY_W-1:0] hit_way,
  input  logic             fill_en,
  input  logic [SET_W-1:0] fill_set,
  input  logic [WAY_W-1:0] fill_way,
  input  logic [SET_W-1:0] rd_set_a,
  output logic [WAY_W-1:0] victim_a,
  input  logic [SET_W-1:0] rd_set_b,
  output logic [WAY_W-1:0] victim_b
);
  // one bit per set names the way that was not touched last
  logic [SETS-1:0] vic_q, vic_d;

  always_comb begin
    vic_d = vic_q;
    if (hit_en)  vic_d[hit_set]  = ~hit_way;
    if (fill_en) vic_d[fill_set] = ~fill_way;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vic_q <= '0;
    else        vic_q <= vic_d;
  end

  assign victim_a = vic_q[rd_set_a];
  assign victim_b = vic_q[rd_set_b];
endmodule

// File: rtl/vxlat_tlb.sv
module vxlat_tlb
  import vxlat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_req,
  input  logic [VA_W-1:0]  lk_vaddr,
  input  logic             lk_write,
  input  logic             lk_kernel,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_miss,
  output logic             rsp_fault,
  output logic [PA_W-1:0]  rsp_paddr,
  input  logic             fill_en,
  input  logic [SET_W-1:0] fill_set,
  input  logic             fill_pick_lru,
  input  logic [WAY_W-1:0] fill_way,
  input  logic [1:0]       fill_rights,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_dirty,
  input  logic             ref_clear,
  input  logic [SET_W-1:0] pr_set,
  input  logic [WAY_W-1:0] pr_way,
  output logic             pr_valid,
  output logic             pr_dirty,
  output logic             pr_ref,
  output logic [1:0]       pr_rights,
  output logic [TAG_W-1:0] pr_tag,
  output logic [PPN_W-1:0] pr_ppn,
  output logic [WAY_W-1:0] pr_victim
);
  // reset asserts at once, releases after two clocks
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [SET_W-1:0] lk_set;
  logic [TAG_W-1:0] lk_tag;
  logic             same_set, look_go;
  logic             hit_any, allowed, good_hit;
  logic [WAY_W-1:0] hit_way, victim_fill, fill_way_eff;
  entry_t           hit_ent;
  entry_t           lk_ent [WAYS];
  entry_t           pr_ent [WAYS];

  assign lk_set   = lk_vaddr[OFF_W +: SET_W];
  assign lk_tag   = lk_vaddr[VA_W-1 -: TAG_W];
  assign same_set = lk_req && fill_en && (fill_set == lk_set);
  assign look_go  = lk_req && !same_set;
  assign good_hit = look_go && hit_any && allowed;
  assign fill_way_eff = fill_pick_lru ? victim_fill : fill_way;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    vxlat_way_store u_store (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .wr_en     (fill_en && (fill_way_eff == WAY_W'(w))),
      .wr_set    (fill_set),
      .wr_rights (rights_e'(fill_rights)),
      .wr_tag    (fill_tag),
      .wr_ppn    (fill_ppn),
      .wr_dirty  (fill_dirty),
      .touch_en  (good_hit && (hit_way == WAY_W'(w))),
      .touch_set (lk_set),
      .touch_wr  (lk_write),
      .ref_clr   (ref_clear),
      .lk_set    (lk_set),
      .lk_entry  (lk_ent[w]),
      .pr_set    (pr_set),
      .pr_entry  (pr_ent[w])
    );
  end

  vxlat_match u_match (
    .ents    (lk_ent),
    .tag     (lk_tag),
    .wr      (lk_write),
    .kern    (lk_kernel),
    .hit_any (hit_any),
    .hit_way (hit_way),
    .hit_ent (hit_ent),
    .allowed (allowed)
  );

  vxlat_lru u_lru (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .hit_en   (good_hit),
    .hit_set  (lk_set),
    .hit_way  (hit_way),
    .fill_en  (fill_en),
    .fill_set (fill_set),
    .fill_way (fill_way_eff),
    .rd_set_a (fill_set),
    .victim_a (victim_fill),
    .rd_set_b (pr_set),
    .victim_b (pr_victim)
  );

  // response register
  logic            rv_d, rh_d, rm_d, rf_d;
  logic [PA_W-1:0] pa_d;
  always_comb begin
    rv_d = lk_req;
    rh_d = good_hit;
    rf_d = look_go && hit_any && !allowed;
    rm_d = lk_req && !rh_d && !rf_d;
    pa_d = rh_d ? {hit_ent.ppn, lk_vaddr[OFF_W-1:0]} : '0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= rv_d;
      rsp_hit   <= rh_d;
      rsp_miss  <= rm_d;
      rsp_fault <= rf_d;
      rsp_paddr <= pa_d;
    end
  end

  assign pr_valid  = pr_ent[pr_way].valid;
  assign pr_dirty  = pr_ent[pr_way].dirty;
  assign pr_ref    = pr_ent[pr_way].refd;
  assign pr_rights = pr_ent[pr_way].rights;
  assign pr_tag    = pr_ent[pr_way].tag;
  assign pr_ppn    = pr_ent[pr_way].ppn;
endmodule

// File: rtl/vxlat_tlb_chk.sv
module vxlat_tlb_chk
  import vxlat_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             lk_req,
  input logic [VA_W-1:0]  lk_vaddr,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             rsp_miss,
  input logic             rsp_fault,
  input logic [PA_W-1:0]  rsp_paddr,
  input logic             fill_en,
  input logic [SET_W-1:0] fill_set
);
  a_r10_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot({rsp_hit, rsp_miss, rsp_fault}));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_hit && !rsp_miss && !rsp_fault && rsp_paddr == '0));

  a_r1_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> rsp_valid);

  a_r1_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> (!rsp_hit || rsp_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0])));

  a_r8_fill_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && fill_en && fill_set == lk_vaddr[OFF_W +: SET_W]) |=> rsp_miss);

  a_r3_fault_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_paddr == '0);

  a_r2_miss_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> rsp_paddr == '0);
endmodule

bind vxlat_tlb vxlat_tlb_chk u_chk (.*);

// File: tb/vxlat_tlb_bench.sv
module vxlat_tlb_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        lk_req = 0, lk_write = 0, lk_kernel = 0;
  logic [39:0] lk_vaddr = '0;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault;
  logic [35:0] rsp_paddr;
  logic        fill_en = 0, fill_pick_lru = 0, fill_way = 0, fill_dirty = 0, ref_clear = 0;
  logic [7:0]  fill_set = '0, pr_set = '0;
  logic [1:0]  fill_rights = '0;
  logic [17:0] fill_tag = '0;
  logic [21:0] fill_ppn = '0;
  logic        pr_way = 0;
  logic        pr_valid, pr_dirty, pr_ref, pr_victim;
  logic [1:0]  pr_rights;
  logic [17:0] pr_tag;
  logic [21:0] pr_ppn;

  vxlat_tlb u_vxlat_tlb (.*);

  int total = 0, bad = 0;
  bit done = 0;

  bit         m_v [256][2];
  bit         m_d [256][2];
  bit         m_r [256][2];
  bit   [1:0] m_rt [256][2];
  bit  [17:0] m_tag [256][2];
  bit  [21:0] m_ppn [256][2];
  bit         m_lru [256];

  function automatic bit perm(input bit [1:0] r, input bit wr, input bit kn);
    if (r == 2'b00) return 0;
    if (r == 2'b01) return !wr;
    if (r == 2'b10) return 1;
    return kn;
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // one cycle: drive at negedge, update model at posedge, check at next negedge
  task automatic cyc(input bit req, input bit [39:0] va, input bit wr, input bit kn,
                     input bit fe, input bit [7:0] fs, input bit flru, input bit fw,
                     input bit [1:0] frt, input bit [17:0] ft, input bit [21:0] fp,
                     input bit fd, input bit rc, input string rq);
    bit [7:0] s; bit [17:0] t; bit conf, ok, eh, ef, em, vw; int hw;
    bit [35:0] epa;
    s = va[21:14]; t = va[39:22];
    conf = req && fe && (fs == s);
    hw = -1;
    for (int w = 1; w >= 0; w--) if (m_v[s][w] && m_tag[s][w] == t) hw = w;
    ok = (hw >= 0) ? perm(m_rt[s][hw], wr, kn) : 1'b0;
    eh = req && !conf && hw >= 0 && ok;
    ef = req && !conf && hw >= 0 && !ok;
    em = req && !eh && !ef;
    epa = eh ? {m_ppn[s][hw], va[13:0]} : 36'd0;
    lk_req = req; lk_vaddr = va; lk_write = wr; lk_kernel = kn;
    fill_en = fe; fill_set = fs; fill_pick_lru = flru; fill_way = fw;
    fill_rights = frt; fill_tag = ft; fill_ppn = fp; fill_dirty = fd; ref_clear = rc;
    @(posedge clk);
    vw = flru ? m_lru[fs] : fw;
    if (eh) begin
      m_r[s][hw] = 1; if (wr) m_d[s][hw] = 1; m_lru[s] = (hw == 0);
    end
    if (rc) for (int i = 0; i < 256; i++) begin m_r[i][0] = 0; m_r[i][1] = 0; end
    if (fe) begin
      m_v[fs][vw] = 1; m_d[fs][vw] = fd; m_r[fs][vw] = 0; m_rt[fs][vw] = frt;
      m_tag[fs][vw] = ft; m_ppn[fs][vw] = fp; m_lru[fs] = !vw;
    end
    @(negedge clk);
    lk_req = 0; fill_en = 0; ref_clear = 0;
    chk({rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_paddr} == {req, eh, em, ef, epa}, rq,
        {24'd0, rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_paddr},
        {24'd0, req, eh, em, ef, epa});
  endtask

  task automatic look(input bit [7:0] s, input bit [17:0] t, input bit [13:0] off,
                      input bit wr, input bit kn, input string rq);
    cyc(1, {t, s, off}, wr, kn, 0, 8'd0, 0, 0, 2'd0, 18'd0, 22'd0, 0, 0, rq);
  endtask

  task automatic fill(input bit [7:0] s, input bit lru, input bit w, input bit [1:0] r,
                      input bit [17:0] t, input bit [21:0] p, input bit d, input string rq);
    cyc(0, 40'd0, 0, 0, 1, s, lru, w, r, t, p, d, 0, rq);
  endtask

  task automatic probe(input bit [7:0] s, input bit w, input string rq);
    bit [44:0] act, exp;
    pr_set = s; pr_way = w;
    #1;
    act = {pr_valid, pr_dirty, pr_ref, pr_victim, 41'd0};
    exp = {m_v[s][w], m_d[s][w], m_r[s][w], m_lru[s], 41'd0};
    if (m_v[s][w]) begin
      act[40:0] = {pr_rights, pr_tag, pr_ppn};
      exp[40:0] = {m_rt[s][w], m_tag[s][w], m_ppn[s][w]};
    end
    chk(act == exp, rq, {19'd0, act}, {19'd0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit [7:0] sets [4];
    bit [17:0] tags [4];
    void'($urandom(32'h5eed));
    sets = '{8'd5, 8'd9, 8'd200, 8'd255};
    tags = '{18'h0abc, 18'h3ffff, 18'h00001, 18'h12345};
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R9: reset state
    probe(8'd5, 0, "R9"); probe(8'd5, 1, "R9"); probe(8'd255, 1, "R9");
    look(8'd5, 18'h0abc, 14'h0, 0, 0, "R9");
    // R10: idle cycle
    cyc(0, 40'd0, 0, 0, 0, 8'd0, 0, 0, 2'd0, 18'd0, 22'd0, 0, 0, "R10");
    // R7/R6: LRU fill into empty set writes way 0 then way 1
    fill(8'd5, 1, 0, 2'b10, 18'h0abc, 22'h2aaaa, 0, "R7");
    probe(8'd5, 0, "R7"); probe(8'd5, 1, "R6");
    look(8'd5, 18'h0abc, 14'h1234, 0, 0, "R1");
    probe(8'd5, 0, "R4");
    look(8'd5, 18'h0abc, 14'h3fff, 1, 0, "R5");
    probe(8'd5, 0, "R5");
    fill(8'd5, 1, 0, 2'b01, 18'h3ffff, 22'h11111, 0, "R7");
    probe(8'd5, 1, "R7");
    look(8'd5, 18'h3ffff, 14'h0007, 0, 0, "R11");
    probe(8'd5, 0, "R6");
    look(8'd5, 18'h3ffff, 14'h0007, 1, 1, "R3");
    probe(8'd5, 1, "R3");
    look(8'd5, 18'h0abc, 14'h0001, 0, 0, "R11");
    probe(8'd5, 0, "R6");
    // R4: clear wins over a hit in the same cycle
    cyc(1, {18'h0abc, 8'd5, 14'h2}, 0, 0, 0, 8'd0, 0, 0, 2'd0, 18'd0, 22'd0, 0, 1, "R4");
    probe(8'd5, 0, "R4"); probe(8'd5, 1, "R4");
    // R3: named-way fills with each permission code
    fill(8'd9, 0, 1, 2'b00, 18'h00001, 22'h00aa0, 1, "R7");
    fill(8'd9, 0, 0, 2'b11, 18'h00002, 22'h3ffff, 0, "R7");
    probe(8'd9, 1, "R7");
    look(8'd9, 18'h00001, 14'h0, 0, 1, "R3");
    look(8'd9, 18'h00002, 14'h10, 0, 0, "R3");
    look(8'd9, 18'h00002, 14'h10, 1, 1, "R3");
    // R8: same-set fill beats lookup, visible next cycle
    cyc(1, {18'h00002, 8'd9, 14'h5}, 0, 1, 1, 8'd9, 0, 0, 2'b10, 18'h00003, 22'h12345, 0, 0, "R8");
    probe(8'd9, 0, "R8");
    look(8'd9, 18'h00003, 14'h5, 0, 0, "R8");
    look(8'd9, 18'h00002, 14'h5, 0, 1, "R2");
    look(8'd200, 18'h00002, 14'h5, 0, 1, "R2");
    // random mix
    for (int n = 0; n < 4000; n++) begin
      bit [7:0] s, fs; bit fe, flru, fw, vw; bit [17:0] ft;
      s  = sets[$urandom % 4];
      fs = sets[$urandom % 4];
      fe = ($urandom % 4) == 0;
      flru = $urandom % 2; fw = $urandom % 2;
      ft = tags[$urandom % 4];
      vw = flru ? m_lru[fs] : fw;
      if (m_v[fs][!vw] && m_tag[fs][!vw] == ft) fe = 0;
      cyc(($urandom % 4) != 0, {tags[$urandom % 4], s, 14'($urandom)}, $urandom % 2, $urandom % 2,
          fe, fs, flru, fw, 2'($urandom), ft, 22'($urandom), $urandom % 2,
          ($urandom % 64) == 0, "R1");
      if (n % 50 == 0) probe(sets[$urandom % 4], $urandom % 2, "R6");
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule